// File: doc/BRIEF.md
# Eight-bit timer/counter with power-of-two prescaler

This block holds an 8-bit count register that advances from one of two sources. In timer mode the source is an instruction-cycle tick: one pulse for every four system clocks. In counter mode the source is an external input pin. The pin is synchronised first, and the block then counts either its rising or its falling transitions.

An optional prescaler sits between the source and the count register. When it is switched in, it divides the event rate by a power of two from 2 to 256. When the count rolls over from FFh to 00h, the block sets a sticky overflow flag. Software clears that flag by writing it.

A small register port reads and writes the count, the option bits and the flag. Each of these writes takes effect at the clock edge on which `wr_en` is sampled high. A read is combinational from `reg_addr`. A write to the count register loads the new value and restarts the instruction-cycle phase. It also clears the prescaler and suppresses counting for the next two instruction cycles, so that the loaded value is visible before counting resumes.

Top module: `tick_timer8`

## Requirements
- R1: After synchronous reset the count, the option bits and the overflow flag all read zero.
- R2: In timer mode (option bit 5 = 0) with the prescaler bypassed (option bit 3 = 0), the count advances by exactly one every 4 system clocks.
- R3: With option bit 3 = 1, the count advances once per 2^(k+1) source events, where k is option bits [2:0] (000 gives 1:2, 111 gives 1:256).
- R4: In counter mode (option bit 5 = 1) with option bit 4 = 0, each rising transition on `ext_pin` advances the count once. The count changes on the third clock edge after the pin changes.
- R5: With option bit 4 = 1, counter mode counts only falling transitions, and rising transitions have no effect on the count.
- R6: A write to register address 0 loads `wr_data` into the count on that edge. It also clears the prescaler and restarts the instruction phase.
- R7: After a count write, the 8 system clocks that follow (2 instruction cycles) produce no increment. In timer mode without the prescaler, the first new increment lands on the 12th edge after the write.
- R8: Every rollover from FFh to 00h sets `ovf_flag`. The flag stays set until a write to address 2 with bit 0 = 0. A write there with bit 0 = 1 leaves the flag unchanged.
- R9: The read map is as follows: address 0 returns the count and address 2 returns the flag in bit 0. Address 1 returns the option bits in [5:0], with bits 7:6 reading 0. Address 3 reads 0.
- R10: In counter mode the count does not move while `ext_pin` is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | External count input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| ovf_flag | output | 1 | Sticky rollover flag |

## Verification
On every cycle the embedded assertions check the following properties:
- The count only ever loads or steps by one.
- No step occurs while the post-write hold is active.
- The flag rises only on an FFh-to-00h rollover, and it never drops without a flag write.
- Instruction ticks and synchronised edge pulses never occur on consecutive cycles.
- The prescaler's masked bits return to zero after it fires.

The exact rates need the bench's scenarios. These are the 1:1 to 1:256 divide ratios, the exact landing cycle after a write, the latency from the pin to the count, and the choice of edge. The bench sweeps every prescale setting against an arithmetic formula, clock by clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W = 8;
    localparam int PSC_W = 8;

    typedef enum logic [1:0] {
        REG_COUNT = 2'd0,
        REG_OPT   = 2'd1,
        REG_FLAG  = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    // option layout: [5] external source, [4] falling edge, [3] prescaler on, [2:0] ratio
    typedef struct packed {
        logic       ext_src;
        logic       fall_edge;
        logic       psc_on;
        logic [2:0] ratio;
    } opt_t;

    // low-bit mask whose all-ones state marks the last event of a 2^(r+1) group
    function automatic logic [PSC_W-1:0] ratio_mask(input logic [2:0] r);
        logic [PSC_W:0] t;
        t = ((PSC_W+1)'(2) << r) - (PSC_W+1)'(1);
        return t[PSC_W-1:0];
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              rise_ev;
    logic              fall_ev;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= pin;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign rise_ev    = chain[STAGES-1] & ~prev;
    assign fall_ev    = ~chain[STAGES-1] & prev;
    assign edge_pulse = fall_sel ? fall_ev : rise_ev;

    // R4: a synchronised level change yields one pulse only
    a_r4_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise_ev |=> !rise_ev);
    // R5: same for falling transitions
    a_r5_single_fall: assert property (@(posedge clk) disable iff (rst)
        fall_ev |=> !fall_ev);

endmodule

// File: rtl/tmr_phase.sv
module tmr_phase #(
    parameter int PER = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int PH_W = (PER > 1) ? $clog2(PER) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(PER - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || restart)     phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign tick = (phase == LAST);

    // R2: instruction ticks are never back to back
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       enable,
    input  logic [2:0] ratio,
    input  logic       src_ev,
    output logic       fire
);
    logic [PSC_W-1:0] psc;
    logic [PSC_W-1:0] mask;

    assign mask = ratio_mask(ratio);

    always_ff @(posedge clk) begin
        if (rst || clear)         psc <= '0;
        else if (enable && src_ev) psc <= psc + 1'b1;
    end

    assign fire = enable ? (src_ev && ((psc & mask) == mask)) : src_ev;

    // R3: after the prescaler fires, its masked group restarts from zero
    a_r3_group_wrap: assert property (@(posedge clk) disable iff (rst)
        (enable && fire && !clear) |=> ((psc & $past(mask)) == '0));

endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
    import tmr_pkg::*;
#(
    parameter int CYC_PER_INSTR = 4,
    parameter int INHIBIT_INSTR = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_pin,
    input  logic             wr_en,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             ovf_flag
);
    localparam int INH_CLKS = CYC_PER_INSTR * INHIBIT_INSTR;
    localparam int INH_W    = $clog2(INH_CLKS + 1);

    logic [CNT_W-1:0] count_q;
    opt_t             opt_q;
    logic             flag_q;
    logic [INH_W-1:0] inh_q;

    logic wr_count, wr_opt, wr_flag;
    logic tick, edge_pulse, src_ev, inc;

    assign wr_count = wr_en && (reg_sel_e'(reg_addr) == REG_COUNT);
    assign wr_opt   = wr_en && (reg_sel_e'(reg_addr) == REG_OPT);
    assign wr_flag  = wr_en && (reg_sel_e'(reg_addr) == REG_FLAG);

    tmr_phase #(.PER(CYC_PER_INSTR)) u_phase (
        .clk(clk), .rst(rst), .restart(wr_count), .tick(tick)
    );

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(ext_pin),
        .fall_sel(opt_q.fall_edge), .edge_pulse(edge_pulse)
    );

    assign src_ev = (opt_q.ext_src ? edge_pulse : tick) && (inh_q == '0);

    tmr_prescaler u_psc (
        .clk(clk), .rst(rst), .clear(wr_count), .enable(opt_q.psc_on),
        .ratio(opt_q.ratio), .src_ev(src_ev), .fire(inc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            opt_q   <= '0;
            flag_q  <= 1'b0;
            inh_q   <= '0;
        end else begin
            if (wr_count)  count_q <= wr_data;
            else if (inc)  count_q <= count_q + 1'b1;

            if (wr_count)           inh_q <= INH_W'(INH_CLKS);
            else if (inh_q != '0)   inh_q <= inh_q - 1'b1;

            if (wr_opt) opt_q <= opt_t'(wr_data[5:0]);

            if (inc && !wr_count && (count_q == '1)) flag_q <= 1'b1;
            else if (wr_flag && !wr_data[0])         flag_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_sel_e'(reg_addr))
            REG_COUNT: rd_data = count_q;
            REG_OPT:   rd_data = {2'b00, opt_q};
            REG_FLAG:  rd_data = {{(CNT_W-1){1'b0}}, flag_q};
            default:   rd_data = '0;
        endcase
    end

    assign ovf_flag = flag_q;

    // R6: a count write is visible on the next cycle
    a_r6_load: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && reg_addr == 2'd0) |-> (count_q == $past(wr_data)));
    // R2: outside of loads the count only steps by one
    a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en && reg_addr == 2'd0) && (count_q != $past(count_q)))
            |-> (count_q == $past(count_q) + 1'b1));
    // R7: no increment while the post-write hold runs
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        ((inh_q != '0) && !(wr_en && reg_addr == 2'd0)) |=> (count_q == $past(count_q)));
    // R8: the flag rises only on a rollover
    a_r8_flag_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> (($past(count_q) == '1) && (count_q == '0)));
    // R8: the flag stays set unless the flag register is written
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !(wr_en && reg_addr == 2'd2)) |=> ovf_flag);

endmodule

// File: tb/tick_timer8_bench.sv
module tick_timer8_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       ext_pin;
    logic       wr_en;
    logic [1:0] reg_addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tick_timer8 u_tick_timer8 (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .wr_en(wr_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .ovf_flag(ovf_flag)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = rd_data;
        reg_addr = 2'd0;
        #1;
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; ext_pin = 1'b0; wr_en = 1'b0; reg_addr = 2'd0; wr_data = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(2'd0, v); check("R1 count", v, 0);
        rd(2'd1, v); check("R1 option", v, 0);
        rd(2'd2, v); check("R1 flag", v, 0);

        // R9 read map
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check("R9 option bits 7:6 zero", v, 8'h3F);
        rd(2'd3, v); check("R9 spare address", v, 0);

        // R2 R3 R6 R7: sweep bypass and every prescale ratio
        for (int cfg = -1; cfg < 8; cfg++) begin
            int d;
            int ticks;
            d = (cfg < 0) ? 1 : (2 << cfg);
            wr(2'd1, (cfg < 0) ? 8'h00 : 8'(8'h08 | cfg));
            wr(2'd0, 8'h10);
            rd(2'd0, v); check("R6 loaded value", v, 8'h10);
            for (int n = 1; n <= 4 * (2 + 2 * d) + 3; n++) begin
                clocks(1);
                ticks = n / 4 - 2;
                if (ticks < 0) ticks = 0;
                rd(2'd0, v);
                if (cfg < 0) check("R2 R7 timer rate", v, 8'h10 + ticks);
                else         check("R3 R7 prescaled rate", v, 8'h10 + ticks / d);
            end
        end

        // R8 rollover and sticky flag
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFE);
        clocks(15);
        rd(2'd0, v); check("R8 count at FF", v, 8'hFF);
        check("R8 flag clear before wrap", ovf_flag, 0);
        clocks(1);
        rd(2'd0, v); check("R8 count wrapped", v, 0);
        check("R8 flag set", ovf_flag, 1);
        wr(2'd2, 8'h01);
        rd(2'd2, v); check("R8 write one keeps flag", v, 1);
        wr(2'd2, 8'h00);
        rd(2'd2, v); check("R8 write zero clears flag", v, 0);
        check("R8 port cleared", ovf_flag, 0);

        // R4 rising edges in counter mode
        wr(2'd1, 8'h20);
        wr(2'd0, 8'h00);
        clocks(10);
        for (int k = 1; k <= 4; k++) begin
            ext_pin = 1'b1;
            clocks(2);
            rd(2'd0, v); check("R4 not yet counted", v, k - 1);
            clocks(1);
            rd(2'd0, v); check("R4 rising edge counted", v, k);
            ext_pin = 1'b0;
            clocks(4);
            rd(2'd0, v); check("R4 falling ignored", v, k);
        end

        // R10 steady pin leaves count alone
        clocks(40);
        rd(2'd0, v); check("R10 steady pin", v, 4);

        // R5 falling edges only
        wr(2'd1, 8'h30);
        clocks(10);
        ext_pin = 1'b1;
        clocks(4);
        rd(2'd0, v); check("R5 rising ignored", v, 4);
        ext_pin = 1'b0;
        clocks(3);
        rd(2'd0, v); check("R5 falling counted", v, 5);

        // R3 prescaler in counter mode, 1:2
        wr(2'd1, 8'h28);
        wr(2'd0, 8'h00);
        clocks(10);
        for (int k = 1; k <= 4; k++) begin
            ext_pin = 1'b1; clocks(4);
            ext_pin = 1'b0; clocks(4);
            rd(2'd0, v); check("R3 counter mode divide by 2", v, k / 2);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule